// File: doc/BRIEF.md
# Stage-2 Permission Decoder

This block turns the permission fields of a second-stage translation descriptor into a three-bit protection vector of read, write and execute. The vector is encoded as {exec, write, read}, with read in bit 0. Read and write come directly from a two-bit access field. Execute comes from a two-bit execute-never code, and that code is read one of two ways.

A feature strap picks the reading. When split user/privileged execute-never is enabled, the code is decoded together with a flag that says whether the first stage of the walk ran at the least-privileged level. When the strap is off, only the upper code bit counts, and execute also depends on the hypervisor-width flag and on the decoded read permission.

The straps are quasi-static: they are sampled together with every request. By default the result is registered. A request is captured on a clock edge where the input valid is high, and the result appears with an output valid one cycle later. Setting the `REGISTERED` parameter to 0 makes the path purely combinational.

Top module: `s2_perm_decoder`

## Requirements
- R1: Output bit 0 (read) is set exactly when bit 0 of the access field is set.
- R2: Output bit 1 (write) is set exactly when bit 1 of the access field is set.
- R3: With the split strap set, execute-never code 0 sets output bit 2 (execute), whatever the first-stage level.
- R4: With the split strap set, code 1 sets execute only when the first stage was least-privileged.
- R5: With the split strap set, code 2 never sets execute.
- R6: With the split strap set, code 3 sets execute only when the first stage was not least-privileged.
- R7: With the split strap clear, an execute-never code with bit 1 set never sets execute. Code bit 0 has no effect in this mode.
- R8: With the split strap clear and code bit 1 clear, execute is set exactly when the hypervisor-width flag is set or read is granted.
- R9: In registered mode, a request with in_valid high at a rising edge gives out_valid high after that edge. out_valid is low after any edge where in_valid was low.
- R10: In registered mode, prot keeps its value across edges where in_valid is low, even when the other inputs change.
- R11: Reset clears prot to 0 and out_valid to 0. Reset takes precedence over a request that is pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| acc_perm | input | 2 | Access field: bit 0 grants read, bit 1 grants write |
| xn_code | input | 2 | Execute-never code |
| s1_least_priv | input | 1 | First stage ran at the least-privileged level |
| split_xn_en | input | 1 | Strap enabling split user/privileged execute-never |
| hyp_is_64 | input | 1 | Hypervisor level runs in 64-bit mode |
| out_valid | output | 1 | Result valid |
| prot | output | 3 | Protection vector {exec, write, read} |

## Verification
Two events can land on the same edge. The first is a back-to-back request: a new request is captured on the very edge where the previous result is being presented. The bench provokes this by keeping in_valid high through the whole vector table. Each vector's result is then judged one cycle after it is driven, and no result may leak into the next.

The second is reset arriving together with a live request. The bench holds in_valid high with a vector that would grant all three permissions and pulls reset. It then judges that prot reads zero and out_valid is low.

// File: rtl/s2_perm_pkg.sv
package s2_perm_pkg;
  localparam int AP_W   = 2;
  localparam int XN_W   = 2;
  localparam int PROT_W = 3;
  localparam int RD_BIT = 0;
  localparam int WR_BIT = 1;
  localparam int EX_BIT = 2;

  typedef logic [AP_W-1:0]   ap_t;
  typedef logic [XN_W-1:0]   xn_t;
  typedef logic [PROT_W-1:0] prot_t;

  // read/write grants straight from the access field
  function automatic logic [1:0] rw_from_ap(input ap_t ap);
    return {ap[1], ap[0]};
  endfunction

  // split user/privileged execute-never decode
  function automatic logic exec_split(input xn_t xn, input logic least_priv);
    case (xn)
      2'd0:    return 1'b1;
      2'd1:    return least_priv;
      2'd2:    return 1'b0;
      default: return !least_priv;
    endcase
  endfunction

  // single execute-never decode: only the upper code bit is looked at
  function automatic logic exec_single(input logic xn_hi, input logic hyp64,
                                       input logic rd);
    return !xn_hi && (hyp64 || rd);
  endfunction
endpackage

// File: rtl/s2_rw_decode.sv
module s2_rw_decode
  import s2_perm_pkg::*;
(
  input  ap_t        ap,
  output logic       rd_ok,
  output logic       wr_ok
);
  logic [1:0] rw;
  assign rw    = rw_from_ap(ap);
  assign rd_ok = rw[0];
  assign wr_ok = rw[1];
endmodule

// File: rtl/s2_exec_decode.sv
module s2_exec_decode
  import s2_perm_pkg::*;
(
  input  xn_t  xn,
  input  logic least_priv,
  input  logic split_en,
  input  logic hyp64,
  input  logic rd_ok,
  output logic ex_ok
);
  logic ex_split;
  logic ex_single;

  assign ex_split  = exec_split(xn, least_priv);
  assign ex_single = exec_single(xn[1], hyp64, rd_ok);
  assign ex_ok     = split_en ? ex_split : ex_single;
endmodule

// File: rtl/s2_prot_stage.sv
module s2_prot_stage
  import s2_perm_pkg::*;
#(
  parameter int REGISTERED = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  prot_t prot_d,
  output logic  vld_q,
  output prot_t prot_q
);
  generate
    if (REGISTERED != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          prot_q <= '0;
        end else begin
          vld_q <= capture;
          if (capture) prot_q <= prot_d;
        end
      end
    end else begin : g_comb
      assign vld_q  = capture;
      assign prot_q = prot_d;
    end
  endgenerate
endmodule

// File: rtl/s2_perm_decoder.sv
module s2_perm_decoder
  import s2_perm_pkg::*;
#(
  parameter int REGISTERED = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [AP_W-1:0]       acc_perm,
  input  logic [XN_W-1:0]       xn_code,
  input  logic                  s1_least_priv,
  input  logic                  split_xn_en,
  input  logic                  hyp_is_64,
  output logic                  out_valid,
  output logic [PROT_W-1:0]     prot
);
  // named internal events
  logic  rd_grant;
  logic  wr_grant;
  logic  ex_grant;
  logic  capture;
  prot_t prot_next;

  assign capture = in_valid;

  s2_rw_decode u_rw (
    .ap    (acc_perm),
    .rd_ok (rd_grant),
    .wr_ok (wr_grant)
  );

  s2_exec_decode u_ex (
    .xn         (xn_code),
    .least_priv (s1_least_priv),
    .split_en   (split_xn_en),
    .hyp64      (hyp_is_64),
    .rd_ok      (rd_grant),
    .ex_ok      (ex_grant)
  );

  always_comb begin
    prot_next         = '0;
    prot_next[RD_BIT] = rd_grant;
    prot_next[WR_BIT] = wr_grant;
    prot_next[EX_BIT] = ex_grant;
  end

  s2_prot_stage #(.REGISTERED(REGISTERED)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .prot_d  (prot_next),
    .vld_q   (out_valid),
    .prot_q  (prot)
  );
endmodule

// File: rtl/s2_perm_decoder_chk.sv
module s2_perm_decoder_chk #(
  parameter int REG = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] acc_perm,
  input logic [1:0] xn_code,
  input logic       s1_least_priv,
  input logic       split_xn_en,
  input logic [2:0] prot,
  input logic       out_valid
);
  generate
    if (REG != 0) begin : g_chk
      // R9
      valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R1
      read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (prot[0] == $past(acc_perm[0])));
      // R2
      write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (prot[1] == $past(acc_perm[1])));
      // R5
      code2_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && split_xn_en && xn_code == 2'd2) |=> !prot[2]);
      // R4
      code1_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && split_xn_en && xn_code == 2'd1) |=> (prot[2] == $past(s1_least_priv)));
      // R7
      single_hi_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !split_xn_en && xn_code[1]) |=> !prot[2]);
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prot));
      // R11
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (prot == 3'b000 && !out_valid));
    end
  endgenerate
endmodule

bind s2_perm_decoder s2_perm_decoder_chk #(.REG(REGISTERED)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .acc_perm      (acc_perm),
  .xn_code       (xn_code),
  .s1_least_priv (s1_least_priv),
  .split_xn_en   (split_xn_en),
  .prot          (prot),
  .out_valid     (out_valid)
);

// File: tb/s2_perm_decoder_bench.sv
`timescale 1ns/1ps
module s2_perm_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] acc_perm = '0;
  logic [1:0] xn_code = '0;
  logic       s1_least_priv = 1'b0;
  logic       split_xn_en = 1'b0;
  logic       hyp_is_64 = 1'b0;
  logic       out_valid;
  logic [2:0] prot;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  s2_perm_decoder u_s2_perm_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_perm(acc_perm),
    .xn_code(xn_code), .s1_least_priv(s1_least_priv), .split_xn_en(split_xn_en),
    .hyp_is_64(hyp_is_64), .out_valid(out_valid), .prot(prot)
  );

  // {split, hyp64, least, xn[1:0], ap[1:0], expected {x,w,r}}
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'd0,2'b00,3'b100},  // R3
    {1'b1,1'b0,1'b1,2'd0,2'b11,3'b111},  // R3
    {1'b1,1'b0,1'b1,2'd1,2'b01,3'b101},  // R4
    {1'b1,1'b0,1'b0,2'd1,2'b01,3'b001},  // R4
    {1'b1,1'b1,1'b0,2'd2,2'b11,3'b011},  // R5
    {1'b1,1'b1,1'b1,2'd2,2'b10,3'b010},  // R5
    {1'b1,1'b0,1'b0,2'd3,2'b10,3'b110},  // R6
    {1'b1,1'b0,1'b1,2'd3,2'b11,3'b011},  // R6
    {1'b0,1'b0,1'b0,2'd1,2'b01,3'b101},  // R7 bit0 ignored, R8 read
    {1'b0,1'b0,1'b0,2'd0,2'b00,3'b000},  // R8
    {1'b0,1'b1,1'b0,2'd0,2'b10,3'b110},  // R8 hyp64
    {1'b0,1'b1,1'b1,2'd2,2'b11,3'b011},  // R7
    {1'b0,1'b1,1'b0,2'd3,2'b01,3'b001},  // R7
    {1'b0,1'b0,1'b1,2'd0,2'b01,3'b101}   // R8
  };

  // independent restatement of the rules
  function automatic logic [2:0] model(input logic sp, input logic hy,
                                       input logic lp, input logic [1:0] xn,
                                       input logic [1:0] ap);
    logic x;
    if (sp) x = (xn == 2'd0) || (xn == 2'd1 && lp) || (xn == 2'd3 && !lp);
    else    x = (xn < 2'd2) && (hy || ap[0]);
    return {x, ap[1], ap[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {valid,prot}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] v);
    split_xn_en   = v[9];
    hyp_is_64     = v[8];
    s1_least_priv = v[7];
    xn_code       = v[6:5];
    acc_perm      = v[4:3];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {out_valid, prot}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, back to back
    in_valid = 1'b1;
    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R1-tbl R3..R8 vector", {out_valid, prot}, {1'b1, VEC[i][2:0]});
      if (i + 1 < NV) drive(VEC[i+1]);
    end

    // exhaustive against model, back to back (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int k = 0; k < 128; k++) begin
      logic [6:0] c;
      c = k[6:0];
      drive({c, 3'b000});
      @(negedge clk);
      check("R8 sweep", {out_valid, prot}, {1'b1, model(c[6], c[5], c[4], c[3:2], c[1:0])});
    end

    // R10 / R9: hold with in_valid low while inputs move
    drive({1'b1,1'b0,1'b0,2'd0,2'b11,3'b000});
    @(negedge clk);
    check("R9 capture", {out_valid, prot}, 4'b1111);
    in_valid = 1'b0;
    drive({1'b1,1'b0,1'b0,2'd2,2'b00,3'b000});
    @(negedge clk);
    check("R9 valid drop", {out_valid, prot}, 4'b0111);
    drive({1'b0,1'b0,1'b0,2'd3,2'b01,3'b000});
    @(negedge clk);
    check("R10 hold", {out_valid, prot}, 4'b0111);

    // R11: reset with a live request
    in_valid = 1'b1;
    drive({1'b1,1'b0,1'b0,2'd0,2'b11,3'b000});
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset beats request", {out_valid, prot}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 recovery", {out_valid, prot}, 4'b1111);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule